// File: doc/BRIEF.md
# Boot Region Write Lock Guard

This block sits in front of the program and erase engine of a 128K x 8 flash array that is divided into 32 pages of 4 KB. Two fixed 16 KB boot regions can each be write-locked: the low one (pages 0 to 3, addresses 00000h to 03FFFh) and the high one (pages 28 to 31, addresses 1C000h to 1FFFFh). Each lock is one-way. A pulse on its set input arms it, and only the power-on reset clears it.

Every program, page erase or chip erase request comes in over a valid/ready handshake. The guard returns one registered accept or reject verdict for it. A rejected request must not be passed on to the array engine. The guard never applies back-pressure: `req_ready` is high whenever reset is released, so a request is taken in any cycle in which `req_valid` is high outside reset. The verdict pulse has no ready signal, and the consumer must take it in the cycle it appears.

Identification-mode status reads go to their own port. Each read returns a byte one cycle later that reports the lock state at one of two special addresses.

Top module: `boot_lock_guard`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `resp_valid` is 0, `id_rd_valid` is 0 and both locks are clear.
- R2: A one-cycle pulse on `set_lo_lock` or `set_hi_lock` arms that lock from the next cycle on. Further pulses have no effect, and only `rst_n` low clears a lock.
- R3: With the low lock armed, a program request (op 00) at any address in 00000h..03FFFh is rejected (`resp_accept` = 0).
- R4: With the high lock armed, a program request at any address in 1C000h..1FFFFh is rejected.
- R5: A program or page erase request whose page is not in an armed region is accepted (`resp_accept` = 1).
- R6: A page erase request (op 01) is rejected when its page, address bits 16:12, is 0..3 with the low lock armed or 28..31 with the high lock armed.
- R7: A chip erase request (op 10) is rejected when either lock is armed and accepted when neither is. Its address is ignored.
- R8: Every handshake (`req_valid` and `req_ready` both high at a clock edge) is followed in the next cycle by exactly one cycle of `resp_valid` = 1. At no other time is `resp_valid` high.
- R9: An identification read at 00002h returns, one cycle later with `id_rd_valid` = 1, the low lock state on bit 0 (1 = locked) and 0 on every other bit.
- R10: An identification read at 1FFF2h returns the high lock state on bit 1 (1 = locked) and 0 on every other bit. A read at any other address returns 00h.
- R11: `req_ready` is 0 while reset is asserted and 1 otherwise. A lock set in the same cycle as a request does not affect the verdict for that request.
- R12: A request carrying the reserved op code 11 is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, the only way to clear the locks |
| set_lo_lock | input | 1 | Arms the low boot region lock |
| set_hi_lock | input | 1 | Arms the high boot region lock |
| req_valid | input | 1 | A request is present |
| req_ready | output | 1 | Guard can take a request |
| req_op | input | 2 | 00 program, 01 page erase, 10 chip erase, 11 reserved |
| req_addr | input | 17 | Byte address of the request |
| resp_valid | output | 1 | One-cycle verdict strobe |
| resp_accept | output | 1 | 1 = request allowed, 0 = rejected |
| id_rd_en | input | 1 | Identification status read strobe |
| id_rd_addr | input | 17 | Identification read address |
| id_rd_valid | output | 1 | Status byte valid |
| id_rd_data | output | 8 | Status byte |

## Verification
The clocked assertions assume that `req_op` and the lock set inputs are driven with known values at every clock edge after reset. They also assume that the lock inputs may change in any cycle, including the cycle of a request. The bench drives all inputs on the falling clock edge and holds them at 0 when idle. It reaches the lock inputs only through one-cycle pulses, and it applies a set pulse and a request together once on purpose. The bench asserts reset in the middle of the run only between requests, so no verdict is lost while reset is active.

// File: rtl/boot_lock_pkg.sv
`timescale 1ns/1ps
package boot_lock_pkg;
  typedef enum logic [1:0] {
    OP_PROG       = 2'b00,
    OP_PAGE_ERASE = 2'b01,
    OP_CHIP_ERASE = 2'b10,
    OP_RSVD       = 2'b11
  } req_op_e;

  localparam int unsigned N_REGIONS = 2;  // index 0: low region, 1: high region
endpackage

// File: rtl/lock_flags.sv
`timescale 1ns/1ps
module lock_flags #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] lock_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lock_o[g] <= 1'b0;
      else if (set_i[g]) lock_o[g] <= 1'b1;
    end

    // R2
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(lock_o[g]) |-> lock_o[g]);
    // R2
    lock_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(set_i[g]) |-> lock_o[g]);
  end
endmodule

// File: rtl/region_match.sv
`timescale 1ns/1ps
module region_match #(
  parameter int unsigned PG_W       = 5,
  parameter int unsigned BOOT_PAGES = 4,
  parameter bit          HIGH_END   = 1'b0
) (
  input  logic [PG_W-1:0] page_i,
  output logic            hit_o
);
  localparam int unsigned NUM_PAGES = 1 << PG_W;

  if (HIGH_END) begin : g_high
    localparam logic [PG_W-1:0] FIRST = PG_W'(NUM_PAGES - BOOT_PAGES);
    assign hit_o = (page_i >= FIRST);
  end else begin : g_low
    localparam logic [PG_W-1:0] LAST = PG_W'(BOOT_PAGES - 1);
    assign hit_o = (page_i <= LAST);
  end
endmodule

// File: rtl/id_status.sv
`timescale 1ns/1ps
module id_status #(
  parameter int unsigned         ADDR_W = 17,
  parameter int unsigned         N      = 2,
  parameter logic [ADDR_W-1:0]   LO_ID  = '0,
  parameter logic [ADDR_W-1:0]   HI_ID  = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [N-1:0]      lock_i,
  output logic              rd_valid,
  output logic [7:0]        rd_data
);
  logic [7:0] byte_d;

  always_comb begin
    byte_d = '0;
    if (rd_addr == LO_ID) byte_d[0] = lock_i[0];
    if (rd_addr == HI_ID) byte_d[1] = lock_i[N-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= rd_en ? byte_d : 8'h00;
    end
  end

  // R9
  id_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_data[7:2] == 6'd0));
  // R9
  id_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (rd_valid == $past(rd_en)));
endmodule

// File: rtl/boot_lock_guard.sv
`timescale 1ns/1ps
module boot_lock_guard
  import boot_lock_pkg::*;
#(
  parameter int unsigned ADDR_W     = 17,
  parameter int unsigned PAGE_BITS  = 12,
  parameter int unsigned BOOT_PAGES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_lo_lock,
  input  logic              set_hi_lock,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              resp_valid,
  output logic              resp_accept,
  input  logic              id_rd_en,
  input  logic [ADDR_W-1:0] id_rd_addr,
  output logic              id_rd_valid,
  output logic [7:0]        id_rd_data
);
  localparam int unsigned       PG_W  = ADDR_W - PAGE_BITS;
  localparam logic [ADDR_W-1:0] LO_ID = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] HI_ID = ADDR_W'((1 << ADDR_W) - 14);

  logic [N_REGIONS-1:0] lock;
  logic [N_REGIONS-1:0] hit;
  logic [PG_W-1:0]      page;
  logic                 take;
  logic                 allow;
  req_op_e              op;
  wire                  unused_low_addr = ^req_addr[PAGE_BITS-1:0];

  assign req_ready = rst_n;
  assign take      = req_valid & req_ready;
  assign page      = req_addr[ADDR_W-1:PAGE_BITS];
  assign op        = req_op_e'(req_op);

  lock_flags #(.N(N_REGIONS)) flags_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  ({set_hi_lock, set_lo_lock}),
    .lock_o (lock)
  );

  for (genvar g = 0; g < N_REGIONS; g++) begin : g_region
    region_match #(
      .PG_W       (PG_W),
      .BOOT_PAGES (BOOT_PAGES),
      .HIGH_END   (g == N_REGIONS - 1)
    ) match_i (
      .page_i (page),
      .hit_o  (hit[g])
    );
  end

  always_comb begin
    unique case (op)
      OP_PROG, OP_PAGE_ERASE: allow = ~|(hit & lock);
      OP_CHIP_ERASE:          allow = ~|lock;
      default:                allow = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid  <= 1'b0;
      resp_accept <= 1'b0;
    end else begin
      resp_valid  <= take;
      resp_accept <= take & allow;
    end
  end

  id_status #(
    .ADDR_W (ADDR_W),
    .N      (N_REGIONS),
    .LO_ID  (LO_ID),
    .HI_ID  (HI_ID)
  ) status_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (id_rd_en),
    .rd_addr  (id_rd_addr),
    .lock_i   (lock),
    .rd_valid (id_rd_valid),
    .rd_data  (id_rd_data)
  );

  // R8
  resp_follows_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(req_valid && req_ready));
  // R8
  take_gets_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> resp_valid);
  // R7
  chip_erase_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && $past(req_op) == OP_CHIP_ERASE && $past(|lock) |-> !resp_accept);
  // R6
  locked_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && $past(req_op) != OP_CHIP_ERASE && $past(|(hit & lock)) |-> !resp_accept);
  // R12
  reserved_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && $past(req_op) == OP_RSVD |-> !resp_accept);
  // R1
  accept_only_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_accept |-> resp_valid);
endmodule

// File: tb/boot_lock_guard_tb_top.sv
`timescale 1ns/1ps
module boot_lock_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        set_lo_lock = 1'b0, set_hi_lock = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'b00;
  logic [16:0] req_addr = '0;
  logic        resp_valid, resp_accept;
  logic        id_rd_en = 1'b0;
  logic [16:0] id_rd_addr = '0;
  logic        id_rd_valid;
  logic [7:0]  id_rd_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  boot_lock_guard dut_i (
    .clk(clk), .rst_n(rst_n), .set_lo_lock(set_lo_lock), .set_hi_lock(set_hi_lock),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_addr(req_addr),
    .resp_valid(resp_valid), .resp_accept(resp_accept), .id_rd_en(id_rd_en),
    .id_rd_addr(id_rd_addr), .id_rd_valid(id_rd_valid), .id_rd_data(id_rd_data)
  );

  // vector fields: [21] set low, [20] set high, [19:18] op, [17:1] addr, [0] expected accept
  localparam int NV = 17;
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 1'b0, 2'b00, 17'h00000, 1'b1},  // R5 unlocked
    {1'b0, 1'b0, 2'b00, 17'h1FFFF, 1'b1},  // R5
    {1'b0, 1'b0, 2'b01, 17'h03000, 1'b1},  // R5
    {1'b0, 1'b0, 2'b10, 17'h00000, 1'b1},  // R7 no lock
    {1'b1, 1'b0, 2'b00, 17'h00000, 1'b0},  // R3
    {1'b0, 1'b0, 2'b00, 17'h03FFF, 1'b0},  // R3
    {1'b0, 1'b0, 2'b00, 17'h04000, 1'b1},  // R5
    {1'b0, 1'b0, 2'b01, 17'h03123, 1'b0},  // R6
    {1'b0, 1'b0, 2'b01, 17'h04000, 1'b1},  // R5
    {1'b0, 1'b0, 2'b00, 17'h1FFFF, 1'b1},  // R5
    {1'b0, 1'b0, 2'b10, 17'h12345, 1'b0},  // R7
    {1'b0, 1'b1, 2'b00, 17'h1C000, 1'b0},  // R4
    {1'b0, 1'b0, 2'b00, 17'h1BFFF, 1'b1},  // R5
    {1'b0, 1'b0, 2'b01, 17'h1F000, 1'b0},  // R6
    {1'b0, 1'b0, 2'b01, 17'h1B000, 1'b1},  // R5
    {1'b0, 1'b0, 2'b10, 17'h00000, 1'b0},  // R7
    {1'b0, 1'b0, 2'b00, 17'h10000, 1'b1}   // R5
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_lo(); @(negedge clk) set_lo_lock = 1'b1; @(negedge clk) set_lo_lock = 1'b0; endtask
  task automatic pulse_hi(); @(negedge clk) set_hi_lock = 1'b1; @(negedge clk) set_hi_lock = 1'b0; endtask

  task automatic do_req(input string req, input logic [1:0] op, input logic [16:0] a, input logic exp);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check("R8", {31'd0, resp_valid}, 32'd1);
    check(req, {31'd0, resp_accept}, {31'd0, exp});
    @(negedge clk);
    check("R8", {31'd0, resp_valid}, 32'd0);
  endtask

  task automatic id_read(input string req, input logic [16:0] a, input logic [7:0] exp);
    @(negedge clk);
    id_rd_en = 1'b1; id_rd_addr = a;
    @(negedge clk);
    id_rd_en = 1'b0;
    check(req, {31'd0, id_rd_valid}, 32'd1);
    check(req, {24'd0, id_rd_data}, {24'd0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11", {31'd0, req_ready}, 32'd0);
    check("R1", {31'd0, resp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", {31'd0, req_ready}, 32'd1);
    check("R1", {31'd0, id_rd_valid}, 32'd0);
    id_read("R1", 17'h00002, 8'h00);
    id_read("R1", 17'h1FFF2, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][21]) pulse_lo();
      if (VEC[i][20]) pulse_hi();
      do_req($sformatf("vector %0d", i), VEC[i][19:18], VEC[i][17:1], VEC[i][0]);
    end

    id_read("R9", 17'h00002, 8'h01);
    id_read("R10", 17'h1FFF2, 8'h02);
    id_read("R10", 17'h00003, 8'h00);
    do_req("R12", 2'b11, 17'h08000, 1'b0);
    pulse_lo();
    id_read("R2", 17'h00002, 8'h01);

    // reset clears both locks
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check("R1", {31'd0, resp_valid}, 32'd0);
    rst_n = 1'b1;
    id_read("R2", 17'h00002, 8'h00);
    id_read("R2", 17'h1FFF2, 8'h00);
    do_req("R2", 2'b00, 17'h00000, 1'b1);

    // set in same cycle as request: verdict uses old state
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'b00; req_addr = 17'h1FFFF; set_hi_lock = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; set_hi_lock = 1'b0;
    check("R11", {31'd0, resp_accept}, 32'd1);
    do_req("R4", 2'b00, 17'h1FFFF, 1'b0);
    do_req("R7", 2'b10, 17'h00000, 1'b0);
    do_req("R5", 2'b00, 17'h00000, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule